// File: doc/BRIEF.md
# Integer RISC Execution Core

This block is a small multi-cycle processor that runs integer programs written as fixed 32-bit instruction words. It fetches one word at a time from an instruction memory port, decodes an 8-bit opcode, three 5-bit register selectors and a 9-bit immediate, and executes arithmetic, logic, shift, load, store and compare-and-branch instructions. It works against a register file of 32 registers of 32 bits each and a simple data memory port. Both memory ports read combinationally, so a read returns its data in the same cycle as the address.

The core steps through named states. `ST_FETCH` latches the instruction word and always moves to `ST_EXEC`. `ST_EXEC` reads the registers, computes the result or the memory address, and resolves any branch. From there it moves to `ST_MEM` for loads and stores, to `ST_WB` for every other legal instruction, and to `ST_HALT` for the halt opcode or an illegal opcode. `ST_MEM` performs the single data access and moves to `ST_WB`. `ST_WB` writes the register file, commits the next program counter and returns to `ST_FETCH`. `ST_HALT` keeps the core there until a synchronous reset.

A program ends with the halt opcode, which leaves the program counter just past that instruction. Any opcode the core does not implement, including the floating-point group, stops the core at the offending word and raises a flag.

Top module: `risc_core`

## Requirements
- R1: An instruction word is split as opcode = bits 31:24, rd = bits 23:19, rs = bits 18:14, rt = bits 13:9 and imm = bits 8:0. The word 0x31088600 is therefore an add with rd=1, rs=2 and rt=3.
- R2: The integer operations write their result to rd. They are 0x30 rs+imm, 0x31 rs+rt, 0x32 rs−rt, 0x33 rs−imm, 0x34 XOR, 0x35 OR and 0x36 AND, the last three taking rs and rt. Sums and differences wrap modulo 2^32.
- R3: The shifts write their result to rd. They are 0x60 rs shifted left by rt, 0x61 rs shifted left by imm, 0x62 rs shifted right by rt and 0x63 rs shifted right by imm. Only the low 5 bits of the amount count, and a right shift fills with zeros.
- R4: Opcode 0x50 stores register rt to byte address rs+imm. Opcode 0x51 loads the word at byte address rs+imm into register rt.
- R5: The branches compare rs with rt: 0x70 equal, 0x71 not equal, 0x72 signed greater-or-equal, 0x73 signed less-or-equal. A taken branch goes to (PC+4)+4·imm, and an untaken one goes to PC+4.
- R6: The immediate is sign-extended from 9 bits when it is used as an operand, an address offset or a branch offset, so 0x1FF means −1.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: Opcode 0x41 stops the core with pc equal to the halt address plus 4. `halted` stays high and pc stays unchanged until reset, and no data memory strobe is driven while halted.
- R9: Any other opcode, including 0x20 to 0x28, stops the core with `illegal` high and pc left at the address of the offending word.
- R10: A synchronous reset sets pc to START_PC and clears `halted` and `illegal`, including when the core was stopped.
- R11: `imem_addr` is the word index pc[IMEM_AW+1:2] of the current program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | IMEM_AW | Word index of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | XLEN | Byte address of the data access |
| dmem_re | output | 1 | Data read strobe, one cycle per load |
| dmem_we | output | 1 | Data write strobe, one cycle per store |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data at `dmem_addr`, combinational |
| pc | output | XLEN | Current program counter (byte address) |
| halted | output | 1 | Core is stopped |
| illegal | output | 1 | Core stopped on an unimplemented opcode |

## Verification
The assertions check on every cycle the properties of the stop condition. `halted` never drops without reset, pc and the memory strobes stay quiet while halted, and the read and write strobes never fire together. On entry to the halted state, pc moves by exactly one instruction after the halt opcode and does not move after an illegal one. They also check that the fetch index follows pc.

The results of arithmetic, shifts, sign extension, branch direction and targets, load and store addressing and register 0 can only be shown by the bench's programs. These programs move values through data memory and compare what the core stores back against values worked out from the requirements.

// File: rtl/risc_pkg.sv
package risc_pkg;

    typedef enum logic [7:0] {
        OP_ADDI = 8'h30, OP_ADD  = 8'h31, OP_SUB  = 8'h32, OP_SUBI = 8'h33,
        OP_XOR  = 8'h34, OP_OR   = 8'h35, OP_AND  = 8'h36,
        OP_HALT = 8'h41,
        OP_ST   = 8'h50, OP_LD   = 8'h51,
        OP_SHL  = 8'h60, OP_SHLI = 8'h61, OP_SHR  = 8'h62, OP_SHRI = 8'h63,
        OP_BEQ  = 8'h70, OP_BNE  = 8'h71, OP_BGE  = 8'h72, OP_BLE  = 8'h73
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_XOR, ALU_OR, ALU_AND, ALU_SHL, ALU_SHR
    } alu_op_e;

    // branch condition; order follows the low opcode bits of the branch group
    typedef enum logic [1:0] {
        BR_EQ = 2'd0, BR_NE = 2'd1, BR_GE = 2'd2, BR_LE = 2'd3
    } br_kind_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_EXEC, ST_MEM, ST_WB, ST_HALT
    } core_state_e;

    typedef struct packed {
        logic     legal;
        logic     stop;
        logic     use_imm;
        logic     wb_en;
        logic     wb_to_rt;
        logic     load;
        logic     store;
        logic     branch;
        alu_op_e  alu_op;
        br_kind_e br_kind;
    } ctrl_t;

endpackage

// File: rtl/risc_decode.sv
module risc_decode
    import risc_pkg::*;
(
    input  logic [7:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl         = '0;
        ctrl.legal   = 1'b1;
        ctrl.alu_op  = ALU_ADD;
        ctrl.br_kind = br_kind_e'(opcode[1:0]);
        unique case (opcode)
            OP_ADDI: begin ctrl.wb_en = 1'b1; ctrl.use_imm = 1'b1; end
            OP_ADD:  ctrl.wb_en = 1'b1;
            OP_SUB:  begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_SUB; end
            OP_SUBI: begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_SUB; ctrl.use_imm = 1'b1; end
            OP_XOR:  begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_XOR; end
            OP_OR:   begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_OR; end
            OP_AND:  begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_AND; end
            OP_SHL:  begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_SHL; end
            OP_SHLI: begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_SHL; ctrl.use_imm = 1'b1; end
            OP_SHR:  begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_SHR; end
            OP_SHRI: begin ctrl.wb_en = 1'b1; ctrl.alu_op = ALU_SHR; ctrl.use_imm = 1'b1; end
            OP_ST:   begin ctrl.store = 1'b1; ctrl.use_imm = 1'b1; end
            OP_LD:   begin
                ctrl.load = 1'b1; ctrl.use_imm = 1'b1;
                ctrl.wb_en = 1'b1; ctrl.wb_to_rt = 1'b1;
            end
            OP_BEQ, OP_BNE, OP_BGE, OP_BLE: ctrl.branch = 1'b1;
            OP_HALT: ctrl.stop = 1'b1;
            default: ctrl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/risc_alu.sv
module risc_alu
    import risc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op,
    input  br_kind_e         br_kind,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  cmp_b,
    output logic [XLEN-1:0]  result,
    output logic             take
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD: result = a + b;
            ALU_SUB: result = a - b;
            ALU_XOR: result = a ^ b;
            ALU_OR:  result = a | b;
            ALU_AND: result = a & b;
            ALU_SHL: result = a << shamt;
            ALU_SHR: result = a >> shamt;
            default: result = '0;
        endcase
    end

    always_comb begin
        unique case (br_kind)
            BR_EQ: take = (a == cmp_b);
            BR_NE: take = (a != cmp_b);
            BR_GE: take = ($signed(a) >= $signed(cmp_b));
            BR_LE: take = ($signed(a) <= $signed(cmp_b));
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/risc_regfile.sv
module risc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  raddr_a,
    input  logic [RAW-1:0]  raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (we && waddr == RAW'(g)) regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/risc_core.sv
module risc_core
    import risc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              IMEM_AW  = 10,
    parameter int              NREG     = 32,
    parameter logic [XLEN-1:0] START_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_rdata,
    output logic [XLEN-1:0]    dmem_addr,
    output logic               dmem_re,
    output logic               dmem_we,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic [XLEN-1:0]    pc,
    output logic               halted,
    output logic               illegal
);
    localparam int RAW   = $clog2(NREG);
    localparam int IMM_W = 9;

    core_state_e     state_q, state_d;
    logic [XLEN-1:0] pc_q, npc_q, res_q;
    logic [31:0]     ir_q;
    logic            illegal_q;

    ctrl_t           ctrl;
    logic [RAW-1:0]  rd_a, rs_a, rt_a, wb_addr;
    logic [XLEN-1:0] imm_sx, rs_val, rt_val, alu_b, alu_res, pc_next4, br_tgt;
    logic            take, rf_we;

    assign rd_a   = ir_q[23:19];
    assign rs_a   = ir_q[18:14];
    assign rt_a   = ir_q[13:9];
    assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

    risc_decode u_decode (.opcode(ir_q[31:24]), .ctrl(ctrl));

    risc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regfile (
        .clk(clk), .we(rf_we), .waddr(wb_addr), .wdata(res_q),
        .raddr_a(rs_a), .raddr_b(rt_a), .rdata_a(rs_val), .rdata_b(rt_val)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

    risc_alu #(.XLEN(XLEN)) u_alu (
        .op(ctrl.alu_op), .br_kind(ctrl.br_kind), .a(rs_val), .b(alu_b),
        .cmp_b(rt_val), .result(alu_res), .take(take)
    );

    assign pc_next4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_next4 + (imm_sx << 2);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                if (!ctrl.legal || ctrl.stop)      state_d = ST_HALT;
                else if (ctrl.load || ctrl.store)  state_d = ST_MEM;
                else                               state_d = ST_WB;
            end
            ST_MEM:   state_d = ST_WB;
            ST_WB:    state_d = ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_FETCH;
            pc_q      <= START_PC;
            npc_q     <= START_PC;
            res_q     <= '0;
            ir_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_FETCH: ir_q <= imem_rdata;
                ST_EXEC: begin
                    res_q <= alu_res;
                    npc_q <= (ctrl.branch && take) ? br_tgt : pc_next4;
                    if (!ctrl.legal)    illegal_q <= 1'b1;
                    else if (ctrl.stop) pc_q      <= pc_next4;
                end
                ST_MEM:  if (ctrl.load) res_q <= dmem_rdata;
                ST_WB:   pc_q <= npc_q;
                ST_HALT: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dmem_re = 1'b0;
        dmem_we = 1'b0;
        rf_we   = 1'b0;
        unique case (state_q)
            ST_MEM: begin
                dmem_re = ctrl.load;
                dmem_we = ctrl.store;
            end
            ST_WB:  rf_we = ctrl.wb_en;
            ST_FETCH, ST_EXEC, ST_HALT: ;
        endcase
    end

    assign wb_addr    = ctrl.wb_to_rt ? rt_a : rd_a;
    assign dmem_addr  = res_q;
    assign dmem_wdata = rt_val;
    assign imem_addr  = pc_q[IMEM_AW+1:2];
    assign pc         = pc_q;
    assign halted     = (state_q == ST_HALT);
    assign illegal    = illegal_q;

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    assert_pc_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));
    assert_quiet_when_halted_R8: assert property (@(posedge clk) disable iff (rst)
        halted |-> !(dmem_re || dmem_we));
    assert_halt_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(halted) && !illegal) |-> pc == $past(pc) + XLEN'(4));
    assert_illegal_pc_held_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(illegal) |-> (halted && $stable(pc)));
    assert_illegal_stops_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);
    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(dmem_re && dmem_we));
    assert_fetch_index_R11: assert property (@(posedge clk) disable iff (rst)
        imem_addr == pc[IMEM_AW+1:2]);
endmodule

// File: tb/risc_core_tb.sv
module risc_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  imem_addr;
    logic [31:0] imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, pc;
    logic        dmem_re, dmem_we, halted, illegal;

    logic [31:0] imem [64];
    logic [31:0] dmem [16];
    int checks = 0;
    int errors = 0;
    int halt_mem_hits = 0;

    always #10 clk = ~clk;

    risc_core u_dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .pc(pc), .halted(halted), .illegal(illegal)
    );

    assign imem_rdata = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[5:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;
    always @(negedge clk) if (halted && (dmem_we || dmem_re)) halt_mem_hits++;

    typedef struct packed {
        logic [7:0]  op;
        logic [8:0]  imm;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h31, 9'h000, 32'd5,         32'd7,         32'd12},
        '{8'h31, 9'h000, 32'hFFFFFFFF,  32'd2,         32'd1},
        '{8'h32, 9'h000, 32'd3,         32'd5,         32'hFFFFFFFE},
        '{8'h30, 9'h1FF, 32'd10,        32'd0,         32'd9},
        '{8'h33, 9'h005, 32'd10,        32'd0,         32'd5},
        '{8'h34, 9'h000, 32'hF0F0F0F0,  32'h0FF00FF0,  32'hFF00FF00},
        '{8'h35, 9'h000, 32'h00FF0000,  32'h0000FF00,  32'h00FFFF00},
        '{8'h36, 9'h000, 32'hF0F0F0F0,  32'hFF00FF00,  32'hF000F000},
        '{8'h60, 9'h000, 32'd1,         32'h24,        32'h10},
        '{8'h61, 9'h01F, 32'd3,         32'd0,         32'h80000000},
        '{8'h62, 9'h000, 32'h80000000,  32'd31,        32'd1},
        '{8'h63, 9'h004, 32'hF0000000,  32'd0,         32'h0F000000}
    };

    function automatic logic [31:0] enc(input logic [7:0] op, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [8:0] imm);
        return {op, rd, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
    endtask

    task automatic run_prog(input string req);
        bit done = 0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (halted) begin done = 1; break; end
        end
        chk({req, " completion"}, 32'(done), 32'd1);
    endtask

    // taken branch leaves 7 in dmem[0], untaken leaves 1
    task automatic branch_case(input string req, input logic [7:0] op,
                               input logic [8:0] va, input logic [8:0] vb,
                               input logic [31:0] exp);
        clear_mem();
        imem[0] = enc(8'h30, 5, 0, 0, 9'd7);
        imem[1] = enc(8'h30, 1, 0, 0, va);
        imem[2] = enc(8'h30, 2, 0, 0, vb);
        imem[3] = enc(op, 0, 1, 2, 9'd1);
        imem[4] = enc(8'h30, 5, 0, 0, 9'd1);
        imem[5] = enc(8'h50, 0, 0, 5, 9'd0);
        imem[6] = enc(8'h41, 0, 0, 0, 9'd0);
        run_prog(req);
        chk(req, dmem[0], exp);
        chk({req, " pc"}, pc, 32'd28);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        // R10: reset state, sampled while reset is still held
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 pc", pc, 32'h0);
        chk("R10 halted", 32'(halted), 32'd0);
        chk("R10 illegal", 32'(illegal), 32'd0);
        chk("R11 fetch index", 32'(imem_addr), 32'd0);

        // R2 R3 R6 vector table: two loads, the operation, a store, halt
        for (int v = 0; v < NV; v++) begin
            string req;
            req = (VECS[v].op[7:4] == 4'h6) ? "R3" : "R2";
            clear_mem();
            dmem[0] = VECS[v].a;
            dmem[1] = VECS[v].b;
            imem[0] = enc(8'h51, 0, 0, 1, 9'd0);
            imem[1] = enc(8'h51, 0, 0, 2, 9'd4);
            imem[2] = enc(VECS[v].op, 3, 1, 2, VECS[v].imm);
            imem[3] = enc(8'h50, 0, 0, 3, 9'd8);
            imem[4] = enc(8'h41, 0, 0, 0, 9'd0);
            run_prog(req);
            chk($sformatf("%s op %h", req, VECS[v].op), dmem[2], VECS[v].exp);
            chk("R8 pc after halt", pc, 32'd20);
        end

        // R1: the fixed word 0x31088600 is ADD rd=1 rs=2 rt=3
        clear_mem();
        imem[0] = enc(8'h30, 2, 0, 0, 9'd20);
        imem[1] = enc(8'h30, 3, 0, 0, 9'd22);
        imem[2] = 32'h31088600;
        imem[3] = enc(8'h50, 0, 0, 1, 9'd0);
        imem[4] = enc(8'h41, 0, 0, 0, 9'd0);
        run_prog("R1");
        chk("R1 field decode", dmem[0], 32'd42);

        // R7: writes to register 0 are dropped
        clear_mem();
        imem[0] = enc(8'h30, 0, 0, 0, 9'd5);
        imem[1] = enc(8'h31, 4, 0, 0, 9'd0);
        imem[2] = enc(8'h50, 0, 0, 4, 9'd12);
        imem[3] = enc(8'h50, 0, 0, 0, 9'd16);
        imem[4] = enc(8'h41, 0, 0, 0, 9'd0);
        dmem[3] = 32'hDEAD;
        dmem[4] = 32'hBEEF;
        run_prog("R7");
        chk("R7 r0 via add", dmem[3], 32'd0);
        chk("R7 r0 stored", dmem[4], 32'd0);

        // R4 R6: negative offsets on store and load
        clear_mem();
        imem[0] = enc(8'h30, 1, 0, 0, 9'd16);
        imem[1] = enc(8'h30, 2, 0, 0, 9'h055);
        imem[2] = enc(8'h50, 0, 1, 2, 9'h1FC);
        imem[3] = enc(8'h51, 0, 1, 3, 9'h1FC);
        imem[4] = enc(8'h50, 0, 0, 3, 9'd0);
        imem[5] = enc(8'h41, 0, 0, 0, 9'd0);
        run_prog("R4");
        chk("R4 R6 store at rs-4", dmem[3], 32'h55);
        chk("R4 load into rt", dmem[0], 32'h55);

        // R5: conditions, signed compare
        branch_case("R5 BEQ equal taken",      8'h70, 9'd5,   9'd5, 32'd7);
        branch_case("R5 BNE equal untaken",    8'h71, 9'd5,   9'd5, 32'd1);
        branch_case("R5 BGE -3,2 untaken",     8'h72, 9'h1FD, 9'd2, 32'd1);
        branch_case("R5 BLE -3,2 taken",       8'h73, 9'h1FD, 9'd2, 32'd7);
        branch_case("R5 BGE 2,2 taken",        8'h72, 9'd2,   9'd2, 32'd7);

        // R5 R6: backward branch loop counts to 3
        clear_mem();
        imem[0] = enc(8'h30, 1, 0, 0, 9'd0);
        imem[1] = enc(8'h30, 2, 0, 0, 9'd3);
        imem[2] = enc(8'h30, 1, 1, 0, 9'd1);
        imem[3] = enc(8'h71, 0, 1, 2, 9'h1FE);
        imem[4] = enc(8'h50, 0, 0, 1, 9'd0);
        imem[5] = enc(8'h41, 0, 0, 0, 9'd0);
        run_prog("R5");
        chk("R5 backward loop", dmem[0], 32'd3);
        chk("R5 loop exit pc", pc, 32'd24);

        // R8: stays halted with pc frozen and no memory traffic
        halt_mem_hits = 0;
        repeat (20) @(negedge clk);
        chk("R8 halted held", 32'(halted), 32'd1);
        chk("R8 pc frozen", pc, 32'd24);
        chk("R8 no strobes while halted", 32'(halt_mem_hits), 32'd0);
        chk("R11 fetch index when halted", 32'(imem_addr), 32'd6);

        // R9: floating-point opcode stops the core at the word
        clear_mem();
        imem[0] = enc(8'h30, 1, 0, 0, 9'd1);
        imem[1] = enc(8'h26, 1, 2, 3, 9'd0);
        imem[2] = enc(8'h50, 0, 0, 1, 9'd0);
        run_prog("R9");
        chk("R9 illegal flag", 32'(illegal), 32'd1);
        chk("R9 pc at offender", pc, 32'd4);
        chk("R9 nothing after", dmem[0], 32'd0);

        // R10: reset clears a stopped core
        rst = 1'b1;
        @(negedge clk);
        chk("R10 halted cleared", 32'(halted), 32'd0);
        chk("R10 illegal cleared", 32'(illegal), 32'd0);
        chk("R10 pc restart", pc, 32'h0);
        rst = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule